// File: doc/BRIEF.md
# Region-Decoded Memory Bus Router

This block sits between a 32-bit processor address bus and three backing memories: a system work RAM, a cartridge RAM and a cartridge ROM. Address bits 26:24 pick the target region. Within a region, only as many low address bits as the memory needs are kept, so each memory repeats across its whole 16 MB window. The cartridge memories can be written through the bus like the work RAM, and this is how a bench or a loader fills the ROM image.

Each request carries an address, a three-bit access type, a write enable and write data. The block aligns the address to the operand size and steers bytes onto little-endian lanes. On reads it sign-extends or zero-extends the result to 32 bits. Writes commit on the request edge. Read data appears one clock later. The work RAM is 64 KB in the full system and is sized by a parameter here. Both cartridge memories take any power-of-two size, or zero to mark them absent.

Top module: `mem_router`

## Requirements
- R1: Address bits 26:24 choose the region: 5 is work RAM, 6 is cartridge RAM, 7 is cartridge ROM. Bits 31:27 have no effect.
- R2: The work RAM is addressed by the low log2(WRAM_BYTES) address bits, so it repeats across region 5.
- R3: Cartridge RAM and ROM are addressed by the address ANDed with their size minus one, so each repeats at its own size.
- R4: Before an access, the low address bits are cleared to a multiple of the operand size. Type codes 0 and 1 are one byte, 2 and 3 are two bytes, and 4 is four bytes.
- R5: Multi-byte operands are little-endian. The byte at the lowest address is the least significant byte.
- R6: Type 0 (byte) and type 2 (halfword) sign-extend read data to 32 bits. Type 1 (byte) and type 3 (halfword) zero-extend it. Type 4 returns the whole word.
- R7: A write stores only the low 1, 2 or 4 bytes of req_wdata, as the type selects. Other bytes of the memory word keep their value.
- R8: Regions 0 to 4 read as zero, and writes to them change no memory.
- R9: A cartridge memory whose size parameter is zero reads as zero and drops writes.
- R10: Type codes 5, 6 and 7 read as zero and write nothing.
- R11: rd_data shows the result of the request presented at the previous rising edge. A write request returns the contents from before that write.
- R12: After a synchronous active-low reset, rd_data is zero until the next request has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read pipeline |
| req_addr | input | 32 | Byte address of the request |
| req_type | input | 3 | Access type: 0 signed byte, 1 unsigned byte, 2 signed half, 3 unsigned half, 4 word |
| req_we | input | 1 | High for a write, low for a read |
| req_wdata | input | 32 | Write data, least significant bytes used |
| rd_data | output | 32 | Extended read result of the previous request |

## Verification
The assertions assume that a request is presented on every clock and that every input is a known value at each rising edge. Under that assumption the extension and zero-result properties can relate the type or region sampled at one edge to rd_data at the next. The bench meets this by driving every input from a single task on the falling edge. It never leaves an input undriven after reset and keeps every address it issues at a fixed value for a full cycle. Memory contents are written before they are read, so no check depends on uninitialised storage.

// File: rtl/mrt_pkg.sv
// Shared constants for the region-decoded memory router.
// Assumes three-bit region and type fields, as the bus defines them.
package mrt_pkg;
    localparam int unsigned BANKS = 3;

    localparam logic [2:0] RGN_FIRST_MEM = 3'd5;

    localparam logic [2:0] K_SBYTE = 3'd0;
    localparam logic [2:0] K_UBYTE = 3'd1;
    localparam logic [2:0] K_SHALF = 3'd2;
    localparam logic [2:0] K_UHALF = 3'd3;
    localparam logic [2:0] K_WORD  = 3'd4;

    // Read-side controls held for one cycle beside the bank outputs.
    typedef struct packed {
        logic       live;
        logic [1:0] bank;
        logic [1:0] offs;
        logic [2:0] kind;
    } rd_ctl_t;
endpackage

// File: rtl/mrt_decode.sv
// Request decode: region field, operand alignment, byte enables and
// lane steering of write data. Pure combinational logic.
// Assumes the type code arrives unfiltered; codes above 4 are flagged invalid.
module mrt_decode
    import mrt_pkg::*;
(
    input  logic [31:0] addr,
    input  logic [2:0]  kind,
    input  logic [31:0] wdata,
    output logic [31:0] addr_al,
    output logic [1:0]  offs,
    output logic [3:0]  lane_en,
    output logic [31:0] lane_data,
    output logic [2:0]  rgn,
    output logic        kind_ok
);
    // Work out the aligned byte offset and the byte lanes the size covers.
    always_comb begin
        kind_ok = 1'b1;
        offs    = 2'b00;
        lane_en = 4'b0000;
        case (kind)
            K_SBYTE, K_UBYTE: begin
                offs    = addr[1:0];
                lane_en = 4'b0001 << addr[1:0];
            end
            K_SHALF, K_UHALF: begin
                offs    = {addr[1], 1'b0};
                lane_en = 4'b0011 << {addr[1], 1'b0};
            end
            K_WORD: begin
                offs    = 2'b00;
                lane_en = 4'b1111;
            end
            default: kind_ok = 1'b0;
        endcase
    end

    assign rgn       = addr[26:24];
    assign addr_al   = {addr[31:2], offs};
    assign lane_data = wdata << {offs, 3'b000};
endmodule

// File: rtl/mrt_bank.sv
// One backing memory, stored as 32-bit words with byte-lane write enables.
// Mirroring comes from keeping only the index bits the size needs.
// Assumes BYTES is zero (absent) or a power of two of at least 8.
// Reads are read-first: a write cycle returns the word before the write.
module mrt_bank #(
    parameter int unsigned BYTES = 1024
) (
    input  logic        clk,
    input  logic        sel,
    input  logic        we,
    input  logic [3:0]  lane_en,
    input  logic [31:0] addr_al,
    input  logic [31:0] lane_data,
    output logic [31:0] rdata
);
    if (BYTES == 0) begin : g_absent
        logic unused_absent;
        assign unused_absent = ^{clk, sel, we, lane_en, addr_al, lane_data};
        assign rdata = '0;
    end else begin : g_present
        localparam int unsigned WORDS = BYTES / 4;
        localparam int unsigned IW    = (WORDS > 1) ? $clog2(WORDS) : 1;

        logic [31:0]   mem [WORDS];
        logic [IW-1:0] idx;
        logic          unused_hi;

        assign idx       = addr_al[IW+1:2];
        assign unused_hi = ^{addr_al[31:IW+2], addr_al[1:0]};

        // Commit enabled byte lanes and capture the old word for reading.
        always_ff @(posedge clk) begin
            if (sel && we) begin
                for (int i = 0; i < 4; i++) begin
                    if (lane_en[i]) mem[idx][8*i +: 8] <= lane_data[8*i +: 8];
                end
            end
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/mrt_extract.sv
// Read-side lane selection and sign or zero extension to 32 bits.
// Assumes offs is already aligned to the operand size of kind.
module mrt_extract
    import mrt_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  offs,
    input  logic [2:0]  kind,
    input  logic        live,
    output logic [31:0] data
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    assign byte_v = word[8*offs +: 8];
    assign half_v = word[16*offs[1] +: 16];

    // Pick the operand bytes and extend them per the type code.
    always_comb begin
        data = '0;
        if (live) begin
            case (kind)
                K_SBYTE: data = {{24{byte_v[7]}}, byte_v};
                K_UBYTE: data = {24'h0, byte_v};
                K_SHALF: data = {{16{half_v[15]}}, half_v};
                K_UHALF: data = {16'h0, half_v};
                K_WORD:  data = word;
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mem_router.sv
// Top of the memory router: decodes the request, drives three banks
// (work RAM, cartridge RAM, cartridge ROM) and forms the registered result.
// Assumes one request per clock; rd_data belongs to the previous request.
module mem_router
    import mrt_pkg::*;
#(
    parameter int unsigned WRAM_BYTES = 4096,
    parameter int unsigned CRAM_BYTES = 2048,
    parameter int unsigned CROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] req_addr,
    input  logic [2:0]  req_type,
    input  logic        req_we,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data
);
    logic [31:0] addr_al;
    logic [1:0]  offs;
    logic [3:0]  lane_en;
    logic [31:0] lane_data;
    logic [2:0]  rgn;
    logic        kind_ok;
    logic        hit_mem;
    logic [31:0] bank_q [BANKS];
    rd_ctl_t     q;
    logic [31:0] sel_word;

    mrt_decode u_dec (
        .addr      (req_addr),
        .kind      (req_type),
        .wdata     (req_wdata),
        .addr_al   (addr_al),
        .offs      (offs),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .rgn       (rgn),
        .kind_ok   (kind_ok)
    );

    assign hit_mem = kind_ok && (rgn >= RGN_FIRST_MEM);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        localparam int unsigned SZ = (g == 0) ? WRAM_BYTES :
                                     (g == 1) ? CRAM_BYTES : CROM_BYTES;
        logic sel;
        assign sel = hit_mem && (rgn == RGN_FIRST_MEM + 3'(g));
        mrt_bank #(.BYTES(SZ)) u_bank (
            .clk       (clk),
            .sel       (sel),
            .we        (req_we),
            .lane_en   (lane_en),
            .addr_al   (addr_al),
            .lane_data (lane_data),
            .rdata     (bank_q[g])
        );
    end

    // Hold the read controls for the cycle in which bank data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q.live <= hit_mem;
            q.bank <= 2'(rgn - RGN_FIRST_MEM);
            q.offs <= offs;
            q.kind <= req_type;
        end
    end

    // Select the returning bank word.
    always_comb begin
        sel_word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (q.bank == 2'(b)) sel_word = bank_q[b];
        end
    end

    mrt_extract u_ext (
        .word (sel_word),
        .offs (q.offs),
        .kind (q.kind),
        .live (q.live),
        .data (rd_data)
    );
endmodule

// File: rtl/mrt_router_chk.sv
// Property checker for mem_router, attached with bind below.
// Assumes one request every clock with known inputs.
module mrt_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] req_addr,
    input logic [2:0]  req_type,
    input logic [31:0] rd_data
);
    // R8: unmapped regions always return zero on the following cycle.
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[26:24] < 3'd5) |=> (rd_data == 32'h0));

    // R10: invalid type codes return zero.
    a_r10_bad_type_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type > 3'd4) |=> (rd_data == 32'h0));

    // R6: unsigned byte leaves upper 24 bits clear.
    a_r6_ubyte_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type == 3'd1) |=> (rd_data[31:8] == 24'h0));

    // R6: unsigned half leaves upper 16 bits clear.
    a_r6_uhalf_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type == 3'd3) |=> (rd_data[31:16] == 16'h0));

    // R6: signed byte copies bit 7 upward.
    a_r6_sbyte_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type == 3'd0) |=> (rd_data[31:7] == '0 || rd_data[31:7] == '1));

    // R6: signed half copies bit 15 upward.
    a_r6_shalf_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type == 3'd2) |=> (rd_data[31:15] == '0 || rd_data[31:15] == '1));
endmodule

bind mem_router mrt_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_addr (req_addr),
    .req_type (req_type),
    .rd_data  (rd_data)
);

// File: tb/tb_mem_router.sv
// Sweep bench: small memories, full readback in every type, mirror aliases.
module tb_mem_router;
    localparam int WSZ = 256;
    localparam int CSZ = 64;
    localparam int RSZ = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_type = 3'd4;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_a, rd_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_w [WSZ];
    logic [7:0] m_c [CSZ];
    logic [7:0] m_r [RSZ];

    always #5 clk = ~clk;

    mem_router #(.WRAM_BYTES(WSZ), .CRAM_BYTES(CSZ), .CROM_BYTES(RSZ)) dut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_type(req_type),
        .req_we(req_we), .req_wdata(req_wdata), .rd_data(rd_a));

    mem_router #(.WRAM_BYTES(WSZ), .CRAM_BYTES(0), .CROM_BYTES(0)) dut_nocart (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_type(req_type),
        .req_we(req_we), .req_wdata(req_wdata), .rd_data(rd_b));

    function automatic int msize(int rg);
        return (rg == 5) ? WSZ : (rg == 6) ? CSZ : (rg == 7) ? RSZ : 0;
    endfunction

    function automatic logic [7:0] mget(int rg, int i);
        case (rg)
            5: return m_w[i];
            6: return m_c[i];
            default: return m_r[i];
        endcase
    endfunction

    function automatic int tsize(logic [2:0] ty);
        return (ty < 2) ? 1 : (ty < 4) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(logic [31:0] a, logic [2:0] ty, bit nocart);
        int rg = int'(a[26:24]);
        int ms = msize(rg);
        int sz = tsize(ty);
        int idx;
        logic [31:0] v = '0;
        if (ty > 4 || rg < 5) return '0;
        if (nocart && rg != 5) return '0;
        idx = int'((a & ~32'(sz - 1)) & 32'(ms - 1));
        for (int i = 0; i < sz; i++) v[8*i +: 8] = mget(rg, idx + i);
        if (ty == 0) v = {{24{v[7]}}, v[7:0]};
        if (ty == 2) v = {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    task automatic model_write(logic [31:0] a, logic [2:0] ty, logic [31:0] wd);
        int rg = int'(a[26:24]);
        int ms = msize(rg);
        int sz = tsize(ty);
        int idx;
        if (ty > 4 || rg < 5) return;
        idx = int'((a & ~32'(sz - 1)) & 32'(ms - 1));
        for (int i = 0; i < sz; i++) begin
            case (rg)
                5: m_w[idx + i] = wd[8*i +: 8];
                6: m_c[idx + i] = wd[8*i +: 8];
                default: m_r[idx + i] = wd[8*i +: 8];
            endcase
        end
    endtask

    task automatic check(string tag, logic [31:0] a, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h got %h expected %h", tag, a, got, exp);
        end
    endtask

    // Drive at falling edge, sample after the next falling edge.
    task automatic access(logic [31:0] a, logic [2:0] ty, logic we, logic [31:0] wd,
                          output logic [31:0] ga, output logic [31:0] gb);
        req_addr = a; req_type = ty; req_we = we; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        ga = rd_a; gb = rd_b;
        if (we) model_write(a, ty, wd);
    endtask

    function automatic logic [31:0] pat(int rg, int k);
        return (32'h9E37_79B9 * 32'(k + 1 + rg * 97)) ^ 32'h5A0F_C3A5;
    endfunction

    function automatic logic [31:0] mk(int hi, int rg, int low);
        return {5'(hi), 3'(rg), 24'(low)};
    endfunction

    initial begin
        logic [31:0] ga, gb, e, ea, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R12 reset", req_addr, rd_a, 32'h0);
        check("R12 reset", req_addr, rd_b, 32'h0);

        // Fill every mapped memory with word writes.
        for (int rg = 5; rg <= 7; rg++)
            for (int w = 0; w < msize(rg) / 4; w++)
                access(mk(0, rg, w * 4), 3'd4, 1'b1, pat(rg, w), ga, gb);

        // Full readback in all types through mirrored aliases.
        for (int rg = 5; rg <= 7; rg++)
            for (int off = 0; off < msize(rg); off++)
                for (int ty = 0; ty <= 4; ty++) begin
                    a = mk(off ^ ty, rg, ((off * 7 + ty) % 3) * msize(rg) + off);
                    e = exp_read(a, 3'(ty), 0);
                    access(a, 3'(ty), 1'b0, 32'h0, ga, gb);
                    check(rg == 5 ? "R1 R2 R4 R5 R6 wram" : "R1 R3 R4 R5 R6 cart", a, ga, e);
                    check(rg == 5 ? "R2 nocart wram" : "R9 absent read", a, gb, exp_read(a, 3'(ty), 1));
                end

        // Narrow writes leave the rest of the word intact.
        for (int k = 0; k < 45; k++) begin
            int rg = 5 + (k % 3);
            a = mk(k, rg, (k * 13) % msize(rg) + msize(rg));
            access(a, 3'(k % 4), 1'b1, pat(9, k), ga, gb);
            ea = mk(0, rg, int'(a[23:0]) & ~3);
            access(ea, 3'd4, 1'b0, 32'h0, ga, gb);
            check("R7 narrow write", ea, ga, exp_read(ea, 3'd4, 0));
            if (rg != 5) check("R9 absent write", ea, gb, 32'h0);
        end

        // Read-first on a write request, then new data next cycle.
        for (int k = 0; k < 6; k++) begin
            int rg = 5 + (k % 3);
            a = mk(0, rg, k * 8);
            e = exp_read(a, 3'd4, 0);
            access(a, 3'd4, 1'b1, pat(3, k), ga, gb);
            check("R11 write returns old", a, ga, e);
            access(a, 3'd4, 1'b0, 32'h0, ga, gb);
            check("R11 next read new", a, ga, pat(3, k));
        end

        // Unmapped regions: zero reads, no writes reach memory.
        for (int rg = 0; rg <= 4; rg++)
            for (int ty = 0; ty <= 4; ty++) begin
                a = mk(3, rg, 16 * ty + 4);
                access(a, 3'(ty), 1'b1, 32'hFFFF_FFFF, ga, gb);
                check("R8 unmapped read", a, ga, 32'h0);
                access(a, 3'(ty), 1'b0, 32'h0, ga, gb);
                check("R8 unmapped read", a, ga, 32'h0);
                ea = mk(0, 5, int'(a[23:0]) & ~3);
                access(ea, 3'd4, 1'b0, 32'h0, ga, gb);
                check("R8 memory untouched", ea, ga, exp_read(ea, 3'd4, 0));
            end

        // Invalid type codes: zero result, nothing written.
        for (int ty = 5; ty <= 7; ty++)
            for (int rg = 5; rg <= 7; rg++) begin
                a = mk(0, rg, 20);
                access(a, 3'(ty), 1'b1, 32'h1234_5678, ga, gb);
                check("R10 bad type read", a, ga, 32'h0);
                access(a, 3'd4, 1'b0, 32'h0, ga, gb);
                check("R10 memory untouched", a, ga, exp_read(a, 3'd4, 0));
            end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule